// File: doc/BRIEF.md
# Eviction Invalidation-Ack Collector

This block runs the back end of a victim eviction from an inclusive second-level cache. When an eviction starts, it copies the victim's data word, its dirty flag and its address into a single transaction buffer. It also loads a signed pending-acknowledgement counter with the number of first-level caches that hold the line. It then sends one invalidation multicast to those caches. After that it collects their acknowledgements and any writeback they return. Once the line is free of first-level copies, it sends either the buffered data or a control-only acknowledgement to memory. It waits for memory to confirm before it releases the buffer.

The caller states which kind of victim it is handing over. A shared victim is held read-only by the first-level caches. An owned victim is held by one first-level cache that may have modified it. An L2-only victim is present in no first-level cache. The dirty flag then selects data or a control ack for the memory message. Only one eviction runs at a time, and `busy` tells the surrounding logic to hold off new starts. While an eviction runs, first-level requests to the victim address are marked for retry. External invalidations are absorbed without effect.

Top module: `evict_ack_collector`

## Requirements
- R1: After reset `busy` is low and `inv_valid`, `mem_data_valid`, `mem_ack_send` and `done` are all low.
- R2: A start accepted while idle for a shared (`evict_kind`=0) or owned (`evict_kind`=1) victim with a nonzero sharer mask raises `inv_valid` for one cycle in the cycle after the start, with `inv_mask` equal to the mask. `busy` is high from that cycle on.
- R3: The pending count is loaded with the number of set bits in the sharer mask. Each `l1_ack_valid` subtracts the signed `l1_ack_count` from it. Only an ack that brings the count to exactly zero is final. A count left nonzero, including a negative one, keeps the block waiting with no memory message.
- R4: On the final ack, the block sends `mem_data_valid` with the buffered data if the buffer is dirty, and `mem_ack_send` otherwise. The pulse comes one cycle later.
- R5: For an owned victim, a dirty writeback (`l1_wb_valid` with `l1_wb_dirty`=1) replaces the buffer data. One cycle later it sends `mem_data_valid` with the written-back data.
- R6: For an owned victim, a clean writeback acts like the final ack. It sends the buffered data if the victim was dirty, and a control ack if not.
- R7: An L2-only victim (`evict_kind`=2), or any victim with an empty sharer mask, sends no invalidation. One cycle after the start it sends data if dirty or a control ack if clean.
- R8: A `mem_ack_valid` while waiting for memory produces a one-cycle `done` pulse in the next cycle. `busy` is low in that same cycle.
- R9: `l1_req_retry` is high, combinationally, exactly when `l1_req_valid` is high, `busy` is high and `l1_req_addr` equals the victim address.
- R10: An external invalidation while busy raises `inv_drop` combinationally and changes no other output or the eviction's outcome.
- R11: A start while busy is ignored: no invalidation, no memory message and no change to the running eviction's data.
- R12: For a shared victim, writebacks are ignored. `mem_data_valid` and `mem_ack_send` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_start | input | 1 | Begin an eviction (taken only when idle) |
| evict_kind | input | 2 | 0 shared, 1 owned by a first-level cache, 2 L2-only |
| evict_dirty | input | 1 | Victim's L2 copy is dirty |
| evict_data | input | DATA_W | Victim data word |
| evict_addr | input | ADDR_W | Victim line address |
| evict_sharers | input | NUM_L1 | First-level holders of the line |
| l1_ack_valid | input | 1 | Invalidation ack from a first-level cache |
| l1_ack_count | input | ACK_W | Signed count carried by the ack |
| l1_wb_valid | input | 1 | Writeback from a first-level cache |
| l1_wb_dirty | input | 1 | Writeback data is modified |
| l1_wb_data | input | DATA_W | Writeback data word |
| mem_ack_valid | input | 1 | Memory confirms the eviction |
| l1_req_valid | input | 1 | First-level request seen |
| l1_req_addr | input | ADDR_W | Address of that request |
| ext_inv_valid | input | 1 | External invalidation seen |
| busy | output | 1 | An eviction is in flight |
| inv_valid | output | 1 | Invalidation multicast pulse |
| inv_mask | output | NUM_L1 | Targets of the invalidation |
| mem_data_valid | output | 1 | Data message to memory |
| mem_data | output | DATA_W | Data sent to memory |
| mem_ack_send | output | 1 | Control-only ack to memory |
| done | output | 1 | Eviction finished, buffer released |
| l1_req_retry | output | 1 | Request hits the victim line, retry later |
| inv_drop | output | 1 | External invalidation absorbed |

## Verification
The bench keeps the defaults of four first-level caches and 8-bit addresses, and narrows the data word to 16 bits. Four sharers are enough to give masks of one, two and three holders. With them, a multi-count ack, a run of single-count acks, and an overshoot to a negative count that a later negative ack repairs are all reachable. The 16-bit data keeps buffered and written-back words distinct, so the bench can tell which one memory received.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [1:0] {
        KIND_SHARED = 2'd0,
        KIND_OWNED  = 2'd1,
        KIND_L2ONLY = 2'd2
    } evict_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_MEMWAIT = 2'd2
    } evc_state_e;

    typedef struct packed {
        logic send_data;
        logic send_ack;
    } mem_sel_t;

    function automatic mem_sel_t pick_mem_msg(input logic dirty);
        mem_sel_t s;
        s.send_data = dirty;
        s.send_ack  = !dirty;
        return s;
    endfunction

endpackage

// File: rtl/evc_sharer_count.sv
module evc_sharer_count #(
    parameter int N  = 4,
    parameter int CW = 4
) (
    input  logic [N-1:0]  mask,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(mask[i]);
        end
    end
endmodule

// File: rtl/evc_pending.sv
module evc_pending #(
    parameter int CW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [CW-1:0]        load_val,
    input  logic                 dec,
    input  logic signed [CW-1:0] dec_val,
    output logic                 reaches_zero
);
    logic signed [CW-1:0] pend_q;
    logic signed [CW-1:0] pend_next;

    assign pend_next    = pend_q - dec_val;
    assign reaches_zero = (pend_next == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (load) begin
            pend_q <= $signed(load_val);
        end else if (dec) begin
            pend_q <= pend_next;
        end
    end
endmodule

// File: rtl/evict_ack_collector.sv
module evict_ack_collector #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int NUM_L1 = 4,
    parameter int ACK_W  = $clog2(NUM_L1 + 1) + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    evict_start,
    input  logic [1:0]              evict_kind,
    input  logic                    evict_dirty,
    input  logic [DATA_W-1:0]       evict_data,
    input  logic [ADDR_W-1:0]       evict_addr,
    input  logic [NUM_L1-1:0]       evict_sharers,
    input  logic                    l1_ack_valid,
    input  logic signed [ACK_W-1:0] l1_ack_count,
    input  logic                    l1_wb_valid,
    input  logic                    l1_wb_dirty,
    input  logic [DATA_W-1:0]       l1_wb_data,
    input  logic                    mem_ack_valid,
    input  logic                    l1_req_valid,
    input  logic [ADDR_W-1:0]       l1_req_addr,
    input  logic                    ext_inv_valid,
    output logic                    busy,
    output logic                    inv_valid,
    output logic [NUM_L1-1:0]       inv_mask,
    output logic                    mem_data_valid,
    output logic [DATA_W-1:0]       mem_data,
    output logic                    mem_ack_send,
    output logic                    done,
    output logic                    l1_req_retry,
    output logic                    inv_drop
);
    import evc_pkg::*;

    evc_state_e        state_q;
    evict_kind_e       kind_q;
    logic              dirty_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] addr_q;

    logic [ACK_W-1:0]  shr_cnt;
    logic              zero_hit;
    logic              start_ok;
    logic              skip_inv;
    logic              wb_take;
    logic              ack_take;
    mem_sel_t          buf_sel;
    mem_sel_t          start_sel;

    evc_sharer_count #(.N(NUM_L1), .CW(ACK_W)) u_count (
        .mask (evict_sharers),
        .cnt  (shr_cnt)
    );

    assign start_ok = evict_start && (state_q == ST_IDLE);
    assign skip_inv = (evict_kind == KIND_L2ONLY) || (shr_cnt == '0);
    assign wb_take  = (state_q == ST_COLLECT) && l1_wb_valid && (kind_q == KIND_OWNED);
    assign ack_take = (state_q == ST_COLLECT) && l1_ack_valid && !wb_take;
    assign buf_sel  = pick_mem_msg(dirty_q);
    assign start_sel = pick_mem_msg(evict_dirty);

    evc_pending #(.CW(ACK_W)) u_pend (
        .clk          (clk),
        .rst          (rst),
        .load         (start_ok),
        .load_val     (shr_cnt),
        .dec          (ack_take),
        .dec_val      (l1_ack_count),
        .reaches_zero (zero_hit)
    );

    assign busy         = (state_q != ST_IDLE);
    assign l1_req_retry = l1_req_valid && busy && (l1_req_addr == addr_q);
    assign inv_drop     = ext_inv_valid && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            kind_q         <= KIND_SHARED;
            dirty_q        <= 1'b0;
            data_q         <= '0;
            addr_q         <= '0;
            inv_valid      <= 1'b0;
            inv_mask       <= '0;
            mem_data_valid <= 1'b0;
            mem_data       <= '0;
            mem_ack_send   <= 1'b0;
            done           <= 1'b0;
        end else begin
            inv_valid      <= 1'b0;
            mem_data_valid <= 1'b0;
            mem_ack_send   <= 1'b0;
            done           <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        kind_q  <= evict_kind_e'(evict_kind);
                        dirty_q <= evict_dirty;
                        data_q  <= evict_data;
                        addr_q  <= evict_addr;
                        if (skip_inv) begin
                            mem_data_valid <= start_sel.send_data;
                            mem_ack_send   <= start_sel.send_ack;
                            mem_data       <= evict_data;
                            state_q        <= ST_MEMWAIT;
                        end else begin
                            inv_valid <= 1'b1;
                            inv_mask  <= evict_sharers;
                            state_q   <= ST_COLLECT;
                        end
                    end
                end
                ST_COLLECT: begin
                    if (wb_take) begin
                        if (l1_wb_dirty) begin
                            data_q         <= l1_wb_data;
                            dirty_q        <= 1'b1;
                            mem_data_valid <= 1'b1;
                            mem_data       <= l1_wb_data;
                        end else begin
                            mem_data_valid <= buf_sel.send_data;
                            mem_ack_send   <= buf_sel.send_ack;
                            mem_data       <= data_q;
                        end
                        state_q <= ST_MEMWAIT;
                    end else if (ack_take && zero_hit) begin
                        mem_data_valid <= buf_sel.send_data;
                        mem_ack_send   <= buf_sel.send_ack;
                        mem_data       <= data_q;
                        state_q        <= ST_MEMWAIT;
                    end
                end
                ST_MEMWAIT: begin
                    if (mem_ack_valid) begin
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/evict_ack_collector_chk.sv
module evict_ack_collector_chk (
    input logic clk,
    input logic rst,
    input logic evict_start,
    input logic busy,
    input logic inv_valid,
    input logic mem_data_valid,
    input logic mem_ack_send,
    input logic done,
    input logic l1_req_retry,
    input logic inv_drop,
    input logic mem_ack_valid
);
    // R12
    mem_msg_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_data_valid, mem_ack_send}));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack_valid) |=> !done);

    // R2
    inv_busy_chk: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> busy);

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && evict_start) |=> !inv_valid);

    // R9
    retry_busy_chk: assert property (@(posedge clk) disable iff (rst)
        l1_req_retry |-> busy);

    // R10
    drop_busy_chk: assert property (@(posedge clk) disable iff (rst)
        inv_drop |-> busy);
endmodule

bind evict_ack_collector evict_ack_collector_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .evict_start    (evict_start),
    .busy           (busy),
    .inv_valid      (inv_valid),
    .mem_data_valid (mem_data_valid),
    .mem_ack_send   (mem_ack_send),
    .done           (done),
    .l1_req_retry   (l1_req_retry),
    .inv_drop       (inv_drop),
    .mem_ack_valid  (mem_ack_valid)
);

// File: tb/evict_ack_collector_tb_top.sv
module evict_ack_collector_tb_top;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int NUM_L1 = 4;
    localparam int ACK_W  = $clog2(NUM_L1 + 1) + 2;

    localparam int EV_INV  = 0;
    localparam int EV_DATA = 1;
    localparam int EV_ACK  = 2;
    localparam int EV_DONE = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                    evict_start = 0;
    logic [1:0]              evict_kind = 0;
    logic                    evict_dirty = 0;
    logic [DATA_W-1:0]       evict_data = 0;
    logic [ADDR_W-1:0]       evict_addr = 0;
    logic [NUM_L1-1:0]       evict_sharers = 0;
    logic                    l1_ack_valid = 0;
    logic signed [ACK_W-1:0] l1_ack_count = 0;
    logic                    l1_wb_valid = 0;
    logic                    l1_wb_dirty = 0;
    logic [DATA_W-1:0]       l1_wb_data = 0;
    logic                    mem_ack_valid = 0;
    logic                    l1_req_valid = 0;
    logic [ADDR_W-1:0]       l1_req_addr = 0;
    logic                    ext_inv_valid = 0;
    logic                    busy, inv_valid, mem_data_valid, mem_ack_send, done;
    logic                    l1_req_retry, inv_drop;
    logic [NUM_L1-1:0]       inv_mask;
    logic [DATA_W-1:0]       mem_data;

    evict_ack_collector #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_L1(NUM_L1), .ACK_W(ACK_W)
    ) dut_i (
        .clk(clk), .rst(rst), .evict_start(evict_start), .evict_kind(evict_kind),
        .evict_dirty(evict_dirty), .evict_data(evict_data), .evict_addr(evict_addr),
        .evict_sharers(evict_sharers), .l1_ack_valid(l1_ack_valid),
        .l1_ack_count(l1_ack_count), .l1_wb_valid(l1_wb_valid),
        .l1_wb_dirty(l1_wb_dirty), .l1_wb_data(l1_wb_data),
        .mem_ack_valid(mem_ack_valid), .l1_req_valid(l1_req_valid),
        .l1_req_addr(l1_req_addr), .ext_inv_valid(ext_inv_valid), .busy(busy),
        .inv_valid(inv_valid), .inv_mask(inv_mask), .mem_data_valid(mem_data_valid),
        .mem_data(mem_data), .mem_ack_send(mem_ack_send), .done(done),
        .l1_req_retry(l1_req_retry), .inv_drop(inv_drop)
    );

    int checks = 0;
    int failures = 0;
    int            exp_kind[$];
    logic [31:0]   exp_val[$];
    string         exp_req[$];

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int k, input logic [31:0] v, input string req);
        exp_kind.push_back(k);
        exp_val.push_back(v);
        exp_req.push_back(req);
    endtask

    task automatic pop_cmp(input int k, input logic [31:0] v);
        if (exp_kind.size() == 0) begin
            chk(1'b0, "R3 unexpected output", 32'(k), 32'hFFFF_FFFF);
        end else begin
            int          ek = exp_kind.pop_front();
            logic [31:0] ev = exp_val.pop_front();
            string       er = exp_req.pop_front();
            chk((ek == k) && (ev == v), er, {k[15:0], v[15:0]}, {ek[15:0], ev[15:0]});
        end
    endtask

    // Monitor: compares every output pulse against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (inv_valid)      pop_cmp(EV_INV, 32'(inv_mask));
            if (mem_data_valid) pop_cmp(EV_DATA, 32'(mem_data));
            if (mem_ack_send)   pop_cmp(EV_ACK, 32'd0);
            if (done) begin
                pop_cmp(EV_DONE, 32'd0);
                chk(!busy, "R8 busy low with done", 32'(busy), 32'd0);
            end
        end
    end

    task automatic do_start(input int kind, input logic dirty, input logic [DATA_W-1:0] d,
                            input logic [NUM_L1-1:0] shr, input logic [ADDR_W-1:0] a);
        @(posedge clk); #1;
        evict_start = 1; evict_kind = 2'(kind); evict_dirty = dirty;
        evict_data = d; evict_sharers = shr; evict_addr = a;
        @(posedge clk); #1;
        evict_start = 0;
    endtask

    task automatic do_ack(input int cnt);
        @(posedge clk); #1;
        l1_ack_valid = 1; l1_ack_count = ACK_W'(cnt);
        @(posedge clk); #1;
        l1_ack_valid = 0;
    endtask

    task automatic do_wb(input logic dirty, input logic [DATA_W-1:0] d);
        @(posedge clk); #1;
        l1_wb_valid = 1; l1_wb_dirty = dirty; l1_wb_data = d;
        @(posedge clk); #1;
        l1_wb_valid = 0;
    endtask

    task automatic do_memack();
        expect_ev(EV_DONE, 0, "R8 done after memory ack");
        @(posedge clk); #1;
        mem_ack_valid = 1;
        @(posedge clk); #1;
        mem_ack_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !inv_valid && !mem_data_valid && !mem_ack_send && !done,
            "R1 reset state", {busy, inv_valid, mem_data_valid, mem_ack_send, done}, 0);
        rst = 0;
        idle(2);
        chk(!busy, "R1 idle after reset", 32'(busy), 0);

        // Clean shared victim, three holders, single-count acks
        expect_ev(EV_INV, 32'hB, "R2 invalidate shared holders");
        do_start(0, 0, 16'h1111, 4'b1011, 8'h10);
        chk(busy, "R2 busy after start", 32'(busy), 1);
        do_ack(1);
        do_ack(1);
        chk(busy, "R3 still waiting with one ack left", 32'(busy), 1);
        do_wb(1, 16'hDEAD);   // R12 shared: writeback ignored
        chk(busy, "R12 shared writeback ignored", 32'(busy), 1);
        ext_inv_valid = 1; #1;
        chk(inv_drop, "R10 external invalidation absorbed", 32'(inv_drop), 1);
        @(posedge clk); #1; ext_inv_valid = 0;
        l1_req_valid = 1; l1_req_addr = 8'h10; #1;
        chk(l1_req_retry, "R9 retry on victim address", 32'(l1_req_retry), 1);
        l1_req_addr = 8'h11; #1;
        chk(!l1_req_retry, "R9 no retry on other address", 32'(l1_req_retry), 0);
        l1_req_valid = 0;
        expect_ev(EV_ACK, 0, "R4 clean final ack sends control ack");
        do_ack(1);
        do_memack();
        idle(1);
        l1_req_valid = 1; l1_req_addr = 8'h10; #1;
        chk(!l1_req_retry, "R9 no retry when idle", 32'(l1_req_retry), 0);
        l1_req_valid = 0;

        // Dirty shared victim, one ack carrying count 2
        expect_ev(EV_INV, 32'h6, "R2 invalidate two holders");
        do_start(0, 1, 16'hA5A5, 4'b0110, 8'h20);
        expect_ev(EV_DATA, 32'hA5A5, "R4 dirty final ack sends data");
        do_ack(2);
        do_memack();

        // Owned victim, dirty writeback from the holder
        expect_ev(EV_INV, 32'h4, "R2 invalidate owner");
        do_start(1, 0, 16'h0BAD, 4'b0100, 8'h30);
        expect_ev(EV_DATA, 32'h1234, "R5 dirty writeback data to memory");
        do_wb(1, 16'h1234);
        do_memack();

        // Owned victim, L2 dirty, clean writeback
        expect_ev(EV_INV, 32'h8, "R2 invalidate owner");
        do_start(1, 1, 16'h7777, 4'b1000, 8'h31);
        expect_ev(EV_DATA, 32'h7777, "R6 clean writeback sends buffered data");
        do_wb(0, 16'h0000);
        do_memack();

        // Owned victim, L2 clean, final ack
        expect_ev(EV_INV, 32'h1, "R2 invalidate owner");
        do_start(1, 0, 16'h4444, 4'b0001, 8'h32);
        expect_ev(EV_ACK, 0, "R6 clean owned final ack sends control ack");
        do_ack(1);
        do_memack();

        // L2-only victims
        expect_ev(EV_DATA, 32'hCAFE, "R7 L2-only dirty sends data at once");
        do_start(2, 1, 16'hCAFE, 4'b0000, 8'h40);
        do_memack();
        expect_ev(EV_ACK, 0, "R7 L2-only clean sends ack at once");
        do_start(2, 0, 16'hBEEF, 4'b1111, 8'h41);
        do_memack();

        // Overshoot to a negative count, then repair
        expect_ev(EV_INV, 32'h3, "R2 invalidate two holders");
        do_start(0, 1, 16'h5A5A, 4'b0011, 8'h50);
        do_ack(3);
        idle(2);
        chk(busy, "R3 negative count keeps waiting", 32'(busy), 1);
        expect_ev(EV_DATA, 32'h5A5A, "R3 negative ack brings count to zero");
        do_ack(-1);
        do_memack();

        // Start while busy is ignored
        expect_ev(EV_INV, 32'h1, "R2 invalidate single holder");
        do_start(0, 1, 16'h1357, 4'b0001, 8'h60);
        do_start(2, 1, 16'hFFFF, 4'b0000, 8'h61);
        idle(2);
        chk(busy, "R11 running eviction unaffected", 32'(busy), 1);
        expect_ev(EV_DATA, 32'h1357, "R11 original data kept");
        do_ack(1);
        do_memack();

        // Shared kind with empty mask goes straight to memory
        expect_ev(EV_ACK, 0, "R7 empty mask sends ack at once");
        do_start(0, 0, 16'h2222, 4'b0000, 8'h70);
        do_memack();

        idle(4);
        chk(exp_kind.size() == 0, "R2 all expected outputs seen", 32'(exp_kind.size()), 0);
        chk(!busy, "R8 idle at end", 32'(busy), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule